// File: doc/BRIEF.md
# DMA Residual Count Accumulator

After a descriptor-driven DMA channel has stopped, this block works out how many bytes of the request were never moved. The caller picks one of two modes with a start pulse. In abort mode the block first writes a control word that clears only the channel's run bit. In wait-only mode it skips that write. In both modes it then polls the channel status until the active bit reads zero, which guarantees that the channel's final status writeback has landed in memory.

The block then reads the descriptor list from its base address, one word at a time. Each descriptor adds one amount to a 32-bit running total. If the channel wrote a result word, the amount is the residual field of that word. If the descriptor never ran, so its result word is still zero, the amount is the request count from its operation word. The walk ends at the stop descriptor. The total is then shown on `residual_o` together with a one-cycle `done_o`. A safety limit ends a list that has no stop descriptor and raises `err_o`.

Top module: `dma_residual_calc`

## Requirements
- R1: A start with `abort_i`=1 causes exactly one control write, in the cycle after the start is taken, carrying 0x8000_0000 (write-enable for run at bit 31, run value bit 15 = 0). A start with `abort_i`=0 causes no control write.
- R2: No descriptor read is issued while `status_i` bit 10 (active) reads 1. Polling continues for as long as the bit stays high.
- R3: An operation word equal to 0x7000_0000 (stop opcode 0x7000 in bits 31:16, zero in bits 15:0) ends the walk and adds nothing. An operation word with 0x7000 in its upper half but a nonzero lower half is an ordinary descriptor.
- R4: A descriptor whose result word is nonzero adds result bits 15:0.
- R5: A descriptor whose result word is zero adds operation-word bits 15:0 (the request count).
- R6: Result bits 31:16 (transfer status) never reach the total. A result word of 0xFFFF_0000 adds 0.
- R7: The 32-bit total is cleared when a walk starts. `done_o` is high for exactly one cycle at the end of the walk. `residual_o` then keeps its value until the next start. After reset all outputs are 0.
- R8: For descriptor i, the operation word is read at base+16*i and then the result word at base+16*i+12. `rd_req_o` is a one-cycle strobe, and no new read is issued before `rd_valid_i` answers the previous one.
- R9: If 512 descriptors have been added and the next operation word is still not a stop, the walk ends with `err_o`=1. The total then holds the sum of those 512 descriptors. A stop found at index 512 ends the walk normally.
- R10: A start that arrives while a walk is in progress is ignored. It changes neither the mode nor the base address.
- R11: `err_o` returns to 0 when the next walk is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| abort_i | input | 1 | Mode, sampled with start: 1 = issue clear-run write first |
| list_base_i | input | 32 | Byte address of descriptor 0, sampled with start |
| status_i | input | 32 | Channel status word, bit 10 = active |
| ctl_wr_o | output | 1 | Channel control write strobe |
| ctl_wdata_o | output | 32 | Channel control write value |
| rd_req_o | output | 1 | Memory read request strobe |
| rd_addr_o | output | 32 | Memory read byte address |
| rd_valid_i | input | 1 | Read data valid |
| rd_data_i | input | 32 | Read data word |
| residual_o | output | 32 | Accumulated residual byte count |
| done_o | output | 1 | One-cycle end-of-walk pulse |
| err_o | output | 1 | Descriptor limit reached without a stop |
| busy_o | output | 1 | Walk in progress |

## Verification
The assertions rely on two properties of the environment. First, once the active bit has fallen it stays low for the rest of the walk, because the stopped channel cannot restart. Second, `rd_valid_i` only ever answers a read that was actually requested. The bench keeps to both. It raises active only before a start and lowers it once, at a chosen poll length. Its memory model returns exactly one response per request, after a per-walk latency of zero to three cycles, and it checks every requested address against the expected sequence of operation and result words.

// File: rtl/rsd_pkg.sv
package rsd_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CLRRUN,
        S_POLL,
        S_REQ_OP,
        S_WAIT_OP,
        S_REQ_RES,
        S_WAIT_RES,
        S_DONE
    } rsd_state_e;

    localparam int DESC_BYTES  = 16;
    localparam int DESC_SHIFT  = $clog2(DESC_BYTES);
    localparam int OP_OFFSET   = 0;
    localparam int RES_OFFSET  = 12;
    localparam int HALF_W      = 16;

endpackage

// File: rtl/rsd_ctrl.sv
module rsd_ctrl
    import rsd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic abort_i,
    input  logic active_i,
    input  logic rd_valid_i,
    input  logic is_stop_i,
    input  logic limit_i,
    output logic accept_o,
    output logic ctl_wr_o,
    output logic rd_req_o,
    output logic sel_res_o,
    output logic op_cap_o,
    output logic add_o,
    output logic done_o,
    output logic busy_o,
    output logic err_o
);

    typedef struct packed {
        rsd_state_e st;
        logic       err;
    } ctrl_t;

    ctrl_t c_q, c_d;

    always_comb begin
        c_d       = c_q;
        accept_o  = 1'b0;
        ctl_wr_o  = 1'b0;
        rd_req_o  = 1'b0;
        sel_res_o = 1'b0;
        op_cap_o  = 1'b0;
        add_o     = 1'b0;
        done_o    = 1'b0;
        unique case (c_q.st)
            S_IDLE: begin
                if (start_i) begin
                    accept_o = 1'b1;
                    c_d.err  = 1'b0;
                    c_d.st   = abort_i ? S_CLRRUN : S_POLL;
                end
            end
            S_CLRRUN: begin
                ctl_wr_o = 1'b1;
                c_d.st   = S_POLL;
            end
            S_POLL: begin
                if (!active_i) c_d.st = S_REQ_OP;
            end
            S_REQ_OP: begin
                rd_req_o = 1'b1;
                c_d.st   = S_WAIT_OP;
            end
            S_WAIT_OP: begin
                if (rd_valid_i) begin
                    if (is_stop_i) begin
                        c_d.st = S_DONE;
                    end else if (limit_i) begin
                        c_d.err = 1'b1;
                        c_d.st  = S_DONE;
                    end else begin
                        op_cap_o = 1'b1;
                        c_d.st   = S_REQ_RES;
                    end
                end
            end
            S_REQ_RES: begin
                rd_req_o  = 1'b1;
                sel_res_o = 1'b1;
                c_d.st    = S_WAIT_RES;
            end
            S_WAIT_RES: begin
                sel_res_o = 1'b1;
                if (rd_valid_i) begin
                    add_o  = 1'b1;
                    c_d.st = S_REQ_OP;
                end
            end
            S_DONE: begin
                done_o = 1'b1;
                c_d.st = S_IDLE;
            end
            default: c_d.st = S_IDLE;
        endcase
    end

    assign busy_o = (c_q.st != S_IDLE);
    assign err_o  = c_q.err;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{st: S_IDLE, err: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

endmodule

// File: rtl/rsd_walk.sv
module rsd_walk
    import rsd_pkg::*;
#(
    parameter int AW       = 32,
    parameter int MAX_DESC = 512
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic [AW-1:0] base_i,
    input  logic          step_i,
    input  logic          sel_res_i,
    output logic [AW-1:0] addr_o,
    output logic          limit_o
);

    localparam int IDXW = $clog2(MAX_DESC + 1);
    localparam logic [AW-1:0] OFS_OP  = AW'(OP_OFFSET);
    localparam logic [AW-1:0] OFS_RES = AW'(RES_OFFSET);
    localparam logic [IDXW-1:0] IDX_LIMIT = IDXW'(MAX_DESC);

    typedef struct packed {
        logic [AW-1:0]   base;
        logic [IDXW-1:0] idx;
    } walk_t;

    walk_t w_q, w_d;
    logic [AW-1:0] desc_ofs;

    always_comb begin
        w_d = w_q;
        if (clear_i) begin
            w_d.base = base_i;
            w_d.idx  = '0;
        end else if (step_i && (w_q.idx != IDX_LIMIT)) begin
            w_d.idx = w_q.idx + 1'b1;
        end
    end

    assign desc_ofs = AW'(w_q.idx) << DESC_SHIFT;
    assign addr_o   = w_q.base + desc_ofs + (sel_res_i ? OFS_RES : OFS_OP);
    assign limit_o  = (w_q.idx == IDX_LIMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q <= '0;
        end else begin
            w_q <= w_d;
        end
    end

endmodule

// File: rtl/rsd_sum.sv
module rsd_sum
    import rsd_pkg::*;
#(
    parameter int DW      = 32,
    parameter int ACC_W   = 32,
    parameter logic [HALF_W-1:0] STOP_OP = 16'h7000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             op_cap_i,
    input  logic             add_i,
    input  logic [DW-1:0]    rd_data_i,
    output logic             is_stop_o,
    output logic [ACC_W-1:0] total_o
);

    localparam logic [DW-1:0] STOP_WORD = {STOP_OP, {(DW-HALF_W){1'b0}}};

    typedef struct packed {
        logic [HALF_W-1:0] req_cnt;
        logic [ACC_W-1:0]  acc;
    } sum_t;

    sum_t s_q, s_d;
    logic             wrote_back;
    logic [HALF_W-1:0] pick;

    assign is_stop_o  = (rd_data_i == STOP_WORD);
    assign wrote_back = (rd_data_i != '0);
    assign pick       = wrote_back ? rd_data_i[HALF_W-1:0] : s_q.req_cnt;

    always_comb begin
        s_d = s_q;
        if (clear_i) begin
            s_d.acc     = '0;
            s_d.req_cnt = '0;
        end else begin
            if (op_cap_i) s_d.req_cnt = rd_data_i[HALF_W-1:0];
            if (add_i)    s_d.acc     = s_q.acc + ACC_W'(pick);
        end
    end

    assign total_o = s_q.acc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/dma_residual_calc.sv
module dma_residual_calc
    import rsd_pkg::*;
#(
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int MAX_DESC   = 512,
    parameter int ACTIVE_BIT = 10,
    parameter int RUN_BIT    = 15,
    parameter logic [15:0] STOP_OP = 16'h7000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          abort_i,
    input  logic [AW-1:0] list_base_i,
    input  logic [DW-1:0] status_i,
    output logic          ctl_wr_o,
    output logic [DW-1:0] ctl_wdata_o,
    output logic          rd_req_o,
    output logic [AW-1:0] rd_addr_o,
    input  logic          rd_valid_i,
    input  logic [DW-1:0] rd_data_i,
    output logic [31:0]   residual_o,
    output logic          done_o,
    output logic          err_o,
    output logic          busy_o
);

    localparam logic [DW-1:0] CLEAR_RUN = DW'(1) << (HALF_W + RUN_BIT);

    logic accept, sel_res, op_cap, add_en, is_stop, limit_hit;
    logic active;
    logic unused_status;

    assign active        = status_i[ACTIVE_BIT];
    assign unused_status = ^status_i;
    assign ctl_wdata_o   = CLEAR_RUN;

    rsd_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .abort_i   (abort_i),
        .active_i  (active),
        .rd_valid_i(rd_valid_i),
        .is_stop_i (is_stop),
        .limit_i   (limit_hit),
        .accept_o  (accept),
        .ctl_wr_o  (ctl_wr_o),
        .rd_req_o  (rd_req_o),
        .sel_res_o (sel_res),
        .op_cap_o  (op_cap),
        .add_o     (add_en),
        .done_o    (done_o),
        .busy_o    (busy_o),
        .err_o     (err_o)
    );

    rsd_walk #(
        .AW      (AW),
        .MAX_DESC(MAX_DESC)
    ) u_walk (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (accept),
        .base_i   (list_base_i),
        .step_i   (add_en),
        .sel_res_i(sel_res),
        .addr_o   (rd_addr_o),
        .limit_o  (limit_hit)
    );

    rsd_sum #(
        .DW     (DW),
        .ACC_W  (32),
        .STOP_OP(STOP_OP)
    ) u_sum (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (accept),
        .op_cap_i (op_cap),
        .add_i    (add_en),
        .rd_data_i(rd_data_i),
        .is_stop_o(is_stop),
        .total_o  (residual_o)
    );

endmodule

// File: rtl/rsd_checker.sv
module rsd_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic        abort_i,
    input logic        active_i,
    input logic        ctl_wr_o,
    input logic        rd_req_o,
    input logic        done_o,
    input logic        err_o,
    input logic        busy_o,
    input logic [31:0] residual_o
);

    p_ctl_after_abort_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr_o |-> $past(start_i && abort_i && !busy_o));

    p_no_read_while_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> !active_i);

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_result_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(residual_o));

    p_one_read_outstanding_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |=> !rd_req_o);

    p_strobes_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctl_wr_o, rd_req_o, done_o}));

    p_err_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> done_o);

    p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && busy_o && !done_o) |=> busy_o);

    p_err_cleared_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> !err_o);

endmodule

bind dma_residual_calc rsd_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .abort_i   (abort_i),
    .active_i  (status_i[ACTIVE_BIT]),
    .ctl_wr_o  (ctl_wr_o),
    .rd_req_o  (rd_req_o),
    .done_o    (done_o),
    .err_o     (err_o),
    .busy_o    (busy_o),
    .residual_o(residual_o)
);

// File: tb/sim_dma_residual_calc.sv
module sim_dma_residual_calc;

    localparam int CLK_PERIOD = 10;
    localparam int MEMN       = 600;
    localparam int MAXD       = 512;
    localparam logic [31:0] STOPW   = 32'h7000_0000;
    localparam logic [31:0] CLR_RUN = 32'h8000_0000;

    typedef struct packed {
        logic        ab;
        logic [1:0]  n;
        logic [3:0]  wt;
        logic [1:0]  lt;
        logic [31:0] o0, o1, o2, r0, r1, r2, ex;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 2'd0, 4'd3, 2'd1, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0},
        '{1'b0, 2'd1, 4'd0, 2'd0, 32'h2000_0100, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h100},
        '{1'b1, 2'd2, 4'd5, 2'd3, 32'h2000_FFF0, 32'h2000_FFF0, 32'h0,
          32'h8400_0010, 32'h0, 32'h0, 32'h0001_0000},
        '{1'b0, 2'd3, 4'd2, 2'd2, 32'h1000_FFF0, 32'h1000_FFF0, 32'h1000_1234,
          32'h0, 32'hFFFF_0000, 32'h8000_0005, 32'h0000_FFF5},
        '{1'b1, 2'd2, 4'd0, 2'd0, 32'h2000_0200, 32'h2000_0040, 32'h0,
          32'h8400_0000, 32'h8400_0000, 32'h0, 32'h0},
        '{1'b0, 2'd3, 4'd1, 2'd1, 32'h2000_FFF0, 32'h2000_FFF0, 32'h2000_FFF0,
          32'h0, 32'h0, 32'h0, 32'h0002_FFD0},
        '{1'b1, 2'd1, 4'd4, 2'd0, 32'h7000_0008, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h8}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        abort_i = 1'b0;
    logic [31:0] list_base_i = '0;
    logic [31:0] status_i = '0;
    logic        ctl_wr_o;
    logic [31:0] ctl_wdata_o;
    logic        rd_req_o;
    logic [31:0] rd_addr_o;
    logic        rd_valid_i = 1'b0;
    logic [31:0] rd_data_i = '0;
    logic [31:0] residual_o;
    logic        done_o, err_o, busy_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_residual_calc u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
        .list_base_i(list_base_i), .status_i(status_i),
        .ctl_wr_o(ctl_wr_o), .ctl_wdata_o(ctl_wdata_o),
        .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
        .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i),
        .residual_o(residual_o), .done_o(done_o), .err_o(err_o), .busy_o(busy_o)
    );

    int checks = 0;
    int fails  = 0;

    logic [31:0] op_mem  [MEMN];
    logic [31:0] res_mem [MEMN];
    logic [31:0] cur_base = '0;
    int          lat_cfg = 0;

    int cyc = 0, ctl_cnt = 0, ctl_bad = 0, last_ctl_cyc = -1;
    int early_cnt = 0, addr_bad = 0, done_cnt = 0;
    logic        pend = 1'b0;
    int          pcnt = 0;
    logic [31:0] paddr = '0;
    logic        phase_res = 1'b0;
    int          exp_idx = 0;

    function automatic logic [31:0] lookup(input logic [31:0] a);
        logic [31:0] rel;
        rel = a - cur_base;
        if ((rel >> 4) >= MEMN) return 32'hDEAD_BEEF;
        if (rel[3:0] == 4'd0)  return op_mem[rel >> 4];
        if (rel[3:0] == 4'd12) return res_mem[rel >> 4];
        return 32'hDEAD_BEEF;
    endfunction

    // Monitor and memory model
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (ctl_wr_o) begin
            ctl_cnt      <= ctl_cnt + 1;
            last_ctl_cyc <= cyc;
            if (ctl_wdata_o != CLR_RUN) ctl_bad <= ctl_bad + 1;
        end
        if (done_o) done_cnt <= done_cnt + 1;
        if (start_i && !busy_o) begin
            phase_res <= 1'b0;
            exp_idx   <= 0;
        end else if (rd_req_o) begin
            if (status_i[10]) early_cnt <= early_cnt + 1;
            if (rd_addr_o != cur_base + 32'(exp_idx) * 32'd16 + (phase_res ? 32'd12 : 32'd0))
                addr_bad <= addr_bad + 1;
            if (pend) addr_bad <= addr_bad + 1;
            if (phase_res) exp_idx <= exp_idx + 1;
            phase_res <= !phase_res;
        end
        if (rd_req_o) begin
            pend       <= 1'b1;
            pcnt       <= lat_cfg;
            paddr      <= rd_addr_o;
            rd_valid_i <= 1'b0;
        end else if (pend && pcnt == 0) begin
            rd_valid_i <= 1'b1;
            rd_data_i  <= lookup(paddr);
            pend       <= 1'b0;
        end else begin
            rd_valid_i <= 1'b0;
            if (pend) pcnt <= pcnt - 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic fill_junk();
        for (int i = 0; i < MEMN; i++) begin
            op_mem[i]  = 32'h3000_0001;
            res_mem[i] = 32'h0000_0002;
        end
    endtask

    task automatic run_walk(input logic ab, input int wt, input int lt, input logic [31:0] base,
                            output logic [31:0] res, output logic er, output bit seen, output int c0);
        lat_cfg  = lt;
        cur_base = base;
        @(negedge clk);
        status_i    = (wt > 0) ? 32'h0000_0401 : 32'h0000_0001;
        abort_i     = ab;
        list_base_i = base;
        start_i     = 1'b1;
        c0          = cyc;
        @(negedge clk);
        start_i = 1'b0;
        abort_i = 1'b0;
        for (int k = 1; k < wt; k++) @(negedge clk);
        status_i = 32'h0000_0001;
        seen = 1'b0;
        for (int k = 0; k < 20000 && !seen; k++) begin
            if (done_o) seen = 1'b1;
            else @(negedge clk);
        end
        res = residual_o;
        er  = err_o;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails + 1);
        $finish;
    end

    initial begin
        logic [31:0] res;
        logic        er;
        bit          seen;
        int          c0, ctl0, early0, addr0, done0;

        fill_junk();
        repeat (3) @(negedge clk);
        // R7: reset state
        chk(!done_o && !err_o && !busy_o && !rd_req_o && !ctl_wr_o, "R7 reset strobes",
            {27'd0, done_o, err_o, busy_o, rd_req_o, ctl_wr_o}, 32'h0);
        chk(residual_o == 32'h0, "R7 reset residual", residual_o, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            fill_junk();
            op_mem[0] = VEC[v].o0; res_mem[0] = VEC[v].r0;
            op_mem[1] = VEC[v].o1; res_mem[1] = VEC[v].r1;
            op_mem[2] = VEC[v].o2; res_mem[2] = VEC[v].r2;
            op_mem[VEC[v].n] = STOPW; res_mem[VEC[v].n] = 32'h0;
            ctl0 = ctl_cnt; early0 = early_cnt; addr0 = addr_bad; done0 = done_cnt;
            run_walk(VEC[v].ab, int'(VEC[v].wt), int'(VEC[v].lt), 32'h0000_4000 + (32'(v) << 12),
                     res, er, seen, c0);
            chk(seen, "R7 done seen", 32'(seen), 32'h1);
            chk(res == VEC[v].ex, "R3 R4 R5 R6 residual", res, VEC[v].ex);
            chk(!er, "R9 no error on stopped list", 32'(er), 32'h0);
            repeat (2) @(negedge clk);
            chk(ctl_cnt - ctl0 == int'(VEC[v].ab), "R1 control write count",
                32'(ctl_cnt - ctl0), 32'(VEC[v].ab));
            if (VEC[v].ab)
                chk(last_ctl_cyc == c0 + 1, "R1 control write cycle",
                    32'(last_ctl_cyc), 32'(c0 + 1));
            chk(early_cnt == early0, "R2 no read while active", 32'(early_cnt - early0), 32'h0);
            chk(addr_bad == addr0, "R8 read address sequence", 32'(addr_bad - addr0), 32'h0);
            chk(done_cnt - done0 == 1, "R7 single done pulse", 32'(done_cnt - done0), 32'h1);
        end
        chk(ctl_bad == 0, "R1 control write value", 32'(ctl_bad), 32'h0);

        // R7: result held after done
        res = residual_o;
        repeat (10) @(negedge clk);
        chk(residual_o == res && !done_o, "R7 result held", residual_o, res);

        // R2: long poll
        fill_junk();
        op_mem[0] = 32'h2000_0020; res_mem[0] = 32'h0;
        op_mem[1] = STOPW;
        early0 = early_cnt;
        run_walk(1'b0, 40, 1, 32'h0002_0000, res, er, seen, c0);
        chk(early_cnt == early0, "R2 long poll no early read", 32'(early_cnt - early0), 32'h0);
        chk(res == 32'h20, "R2 long poll residual", res, 32'h20);

        // R10: start while busy ignored
        fill_junk();
        op_mem[0] = 32'h2000_0044; res_mem[0] = 32'h0;
        op_mem[1] = STOPW;
        ctl0 = ctl_cnt; addr0 = addr_bad;
        lat_cfg  = 0;
        cur_base = 32'h0003_0000;
        @(negedge clk);
        status_i = 32'h0000_0400; abort_i = 1'b0; list_base_i = 32'h0003_0000; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        start_i = 1'b1; abort_i = 1'b1; list_base_i = 32'h0005_0000;
        repeat (2) @(negedge clk);
        start_i = 1'b0; abort_i = 1'b0;
        repeat (3) @(negedge clk);
        status_i = 32'h0;
        seen = 1'b0;
        for (int k = 0; k < 2000 && !seen; k++) begin
            if (done_o) seen = 1'b1;
            else @(negedge clk);
        end
        res = residual_o;
        repeat (2) @(negedge clk);
        chk(ctl_cnt == ctl0, "R10 late abort ignored", 32'(ctl_cnt - ctl0), 32'h0);
        chk(res == 32'h44 && addr_bad == addr0, "R10 base unchanged", res, 32'h44);

        // R9: exactly 512 descriptors then stop at index 512
        fill_junk();
        for (int i = 0; i < MAXD; i++) begin
            op_mem[i] = 32'h2000_0001; res_mem[i] = 32'h0;
        end
        op_mem[MAXD] = STOPW;
        run_walk(1'b0, 0, 0, 32'h0010_0000, res, er, seen, c0);
        chk(seen && !er, "R9 stop at index 512 no error", 32'(er), 32'h0);
        chk(res == 32'd512, "R9 residual 512", res, 32'd512);

        // R9: no stop, limit reached
        op_mem[MAXD] = 32'h2000_0001;
        addr0 = addr_bad;
        run_walk(1'b1, 2, 0, 32'h0020_0000, res, er, seen, c0);
        chk(seen && er, "R9 limit error", 32'(er), 32'h1);
        chk(res == 32'd512, "R9 limit residual", res, 32'd512);
        repeat (2) @(negedge clk);
        chk(addr_bad == addr0, "R8 long list addresses", 32'(addr_bad - addr0), 32'h0);

        // R11: next start clears error
        fill_junk();
        op_mem[0] = STOPW;
        run_walk(1'b0, 0, 0, 32'h0000_8000, res, er, seen, c0);
        chk(seen && !er, "R11 error cleared", 32'(er), 32'h0);
        chk(res == 32'h0, "R7 cleared on start", res, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule